// File: doc/BRIEF.md
# Dual-Channel Input Capture Timer

This block measures the timing of external digital signals. A 16-bit up-counter advances once per prescaled tick. An 8-bit prescale value sets the tick: the counter steps once every (prescale + 1) clock cycles. Each of two capture pins passes through a synchronizer and an edge detector. When a selected edge is seen on a pin, the current count is copied into that channel's capture register.

Either channel can also restart the counter and the prescaler on its capture. With that option, one channel that restarts on a rising edge gives the period of a signal directly, with no overflow bookkeeping. A second channel that captures on the falling edge of the same signal gives the high time. Software drives the block through a small word-wide register interface. It sets run control, a low-power freeze, the prescale value and the per-channel edge configuration. It also enables interrupts and clears pending bits by writing 1.

Top module: `cap_timer`

Register map (addr_i, all fields start at zero after reset):

| Addr | Contents |
|------|----------|
| 0 | bit0 run, bit1 sleep (low-power freeze) |
| 1 | prescale value, bits [7:0] |
| 2 | channel 0 config in [2:0], channel 1 config in [6:4]; per field: bit0 rising edge, bit1 falling edge, bit2 restart counter on capture |
| 3 | interrupt enable, bits [2:0] |
| 4 | pending: bit0 channel 0 capture, bit1 channel 1 capture, bit2 counter wrap; write 1 to clear |
| 5 | counter |
| 6 | channel 0 capture register |
| 7 | channel 1 capture register |

## Requirements
- R1: While run is set and sleep is clear, the counter reads floor(n/(P+1)) n cycles after a write of 0 to the counter, where P is the prescale value. A counter write also clears the prescaler.
- R2: A capture event on channel 0 loads the capture register at addr 6, and a capture event on channel 1 loads the capture register at addr 7. The value loaded is the count held in the cycle of the event. The event falls two clocks after the first clock edge that samples the new pin level.
- R3: A channel recognizes a rising edge only when config bit0 is set, and a falling edge only when config bit1 is set. Each recognized edge sets that channel's pending bit (bit0 or bit1).
- R4: With config bit2 set, a capture event also clears the counter and the prescaler. The capture register keeps the count from before the clear.
- R5: With run clear, the counter holds its value and no capture event is recognized.
- R6: With sleep set, the counter and prescaler hold their values and no capture is recognized. Writes to the counter and capture registers are ignored. Writes to the control, prescale, config and enable registers still take effect.
- R7: With sleep set, a write of 1 to a pending bit leaves it set.
- R8: A counter step from 0xFFFF to 0 sets pending bit2. Writing 1 to a pending bit clears it outside sleep. irq_o is high exactly when some pending bit and its enable bit are both set.
- R9: When both channels capture in the same cycle, both capture registers load the same count. If either channel requests a restart, the counter restarts once.
- R10: After reset every register reads 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register (combinational) |
| cap_pin_i | input | 2 | Asynchronous capture pins, bit0 channel 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge where wr_en_i is high. Read data follows addr_i combinationally, so the bench changes inputs on falling edges and reads one time step after setting the address. A pin change made before clock edge n reaches the edge detector at edge n+1 and produces its event at edge n+2. From this, the period and high-time sweeps over all prescale values 0 to 3 predict each captured count as floor((D-1)/(P+1)), where D is the spacing in cycles between the restart event and the measuring event. Pending bits, the restart on capture and the two simultaneous captures are therefore read back three or more falling edges after the pin change.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_PSC  = 3'd1,
    A_CFG  = 3'd2,
    A_IEN  = 3'd3,
    A_PEND = 3'd4,
    A_CNT  = 3'd5,
    A_CAP0 = 3'd6,
    A_CAP1 = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic rst_on_cap;
    logic fall;
    logic rise;
  } ch_cfg_t;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_timer_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pin_i,
  input  logic    en_i,
  input  ch_cfg_t cfg_i,
  output logic    event_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= lvl;
    end
  end

  assign event_o = en_i & ((cfg_i.rise & lvl & ~prev_q) |
                           (cfg_i.fall & ~lvl & prev_q));
endmodule

// File: rtl/cap_tick_counter.sv
module cap_tick_counter #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PS_W-1:0]  psc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [PS_W-1:0]  psc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  // >= keeps the tick alive if the prescale drops below the running value
  assign tick   = run_i & (psc_q >= psc_i);
  assign wrap_o = tick & (&cnt_q) & ~load_i & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      psc_q <= '0;
      cnt_q <= load_val_i;
    end else if (clr_i) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else if (run_i) begin
      if (tick) begin
        psc_q <= '0;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        psc_q <= psc_q + 1'b1;
      end
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/cap_reg.sv
module cap_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] cap_val_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= cap_val_i;
    else if (wr_i)  q_o <= wdata_i;
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0] cap_pin_i,
  output logic              irq_o
);
  localparam int PEND_W = NUM_CH + 1;
  localparam int CFG_STRIDE = 4;

  logic              run_q, sleep_q, active;
  logic [PS_W-1:0]   psc_q;
  ch_cfg_t           cfg_q [NUM_CH];
  logic [PEND_W-1:0] ien_q, pend_q, pend_set, pend_clr;
  logic [NUM_CH-1:0] cap_ev, rst_req;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  cap_val [NUM_CH];
  logic              cap_rst, cnt_wr, wrap;
  logic [CNT_W-1:0]  cfg_rd;

  assign active = run_q & ~sleep_q;
  assign cnt_wr = wr_en_i & (addr_i == A_CNT) & ~sleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      sleep_q <= 1'b0;
      psc_q   <= '0;
      ien_q   <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL: begin
          run_q   <= wdata_i[0];
          sleep_q <= wdata_i[1];
        end
        A_PSC: psc_q <= wdata_i[PS_W-1:0];
        A_IEN: ien_q <= wdata_i[PEND_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic cap_wr;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[i] <= '0;
      else if (wr_en_i && addr_i == A_CFG)
        cfg_q[i] <= wdata_i[i*CFG_STRIDE +: 3];
    end

    cap_edge_det #(.STAGES(SYNC_STAGES)) edge_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (cap_pin_i[i]),
      .en_i    (active),
      .cfg_i   (cfg_q[i]),
      .event_o (cap_ev[i])
    );

    assign rst_req[i] = cap_ev[i] & cfg_q[i].rst_on_cap;
    assign cap_wr = wr_en_i & ~sleep_q & (addr_i == A_CAP0 + 3'(i));

    cap_reg #(.W(CNT_W)) cap_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cap_i     (cap_ev[i]),
      .cap_val_i (count),
      .wr_i      (cap_wr),
      .wdata_i   (wdata_i),
      .q_o       (cap_val[i])
    );

    assign cfg_rd[i*CFG_STRIDE +: CFG_STRIDE] = {1'b0, cfg_q[i]};
  end

  if (CNT_W > NUM_CH*CFG_STRIDE) begin : g_cfg_pad
    assign cfg_rd[CNT_W-1:NUM_CH*CFG_STRIDE] = '0;
  end

  assign cap_rst = |rst_req;

  cap_tick_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) cnt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (active),
    .psc_i      (psc_q),
    .load_i     (cnt_wr),
    .load_val_i (wdata_i),
    .clr_i      (cap_rst),
    .count_o    (count),
    .wrap_o     (wrap)
  );

  assign pend_set = {wrap, cap_ev};
  assign pend_clr = (wr_en_i && addr_i == A_PEND && !sleep_q) ?
                    wdata_i[PEND_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~pend_clr) | pend_set;
  end

  assign irq_o = |(pend_q & ien_q);

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = CNT_W'({sleep_q, run_q});
      A_PSC:   rdata_o = CNT_W'(psc_q);
      A_CFG:   rdata_o = cfg_rd;
      A_IEN:   rdata_o = CNT_W'(ien_q);
      A_PEND:  rdata_o = CNT_W'(pend_q);
      A_CNT:   rdata_o = count;
      A_CAP0:  rdata_o = cap_val[0];
      default: rdata_o = cap_val[1];
    endcase
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             sleep,
  input logic             cnt_wr,
  input logic             cap_rst,
  input logic [1:0]       cap_ev,
  input logic             wrap,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap0,
  input logic [CNT_W-1:0] cap1,
  input logic [2:0]       pend
);
  // R1
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr && !cap_rst) |=> (count == $past(count) ||
                               count == $past(count) + 1'b1 || count == '0));

  // R2
  cap0_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev[0] |=> cap0 == $past(count));

  // R4
  cap_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_rst && !cnt_wr) |=> count == '0);

  // R5
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_wr) |=> $stable(count));

  // R5
  run_nocap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> cap_ev == 2'b00);

  // R6
  sleep_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep |=> $stable(count));

  // R7
  sleep_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep |=> ((pend & $past(pend)) == $past(pend)));

  // R8
  wrap_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> pend[2]);

  // R9
  same_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cap_ev) |=> cap0 == cap1);
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run     (run_q),
  .sleep   (sleep_q),
  .cnt_wr  (cnt_wr),
  .cap_rst (cap_rst),
  .cap_ev  (cap_ev),
  .wrap    (wrap),
  .count   (count),
  .cap0    (cap_val[0]),
  .cap1    (cap_val[1]),
  .pend    (pend_q)
);

// File: tb/cap_timer_tb.sv
module cap_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  cap_pin_i = 2'b00;
  logic        irq_o;

  int vectors = 0;
  int errs = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  cap_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cap_pin_i(cap_pin_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr_i = a;
    #1;
    v = int'(rdata_o);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    int v, v2, c;
    rst_ni = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R10: reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R10 reg%0d", a), v, 0);
    end
    chk("R10 irq", int'(irq_o), 0);

    // R1: prescale sweep
    wr(3'd0, 16'h0001);
    for (int p = 0; p < 4; p++) begin
      wr(3'd1, 16'(p));
      wr(3'd5, 16'h0000);
      for (int n = 1; n <= 12; n++) begin
        @(negedge clk_i);
        rd(3'd5, v);
        chk($sformatf("R1 p=%0d n=%0d", p, n), v, n / (p + 1));
      end
    end

    // R3: edge select sweep on channel 0
    wr(3'd1, 16'h0000);
    for (int cfg = 0; cfg < 8; cfg++) begin
      wr(3'd2, 16'(cfg));
      wr(3'd4, 16'h0007);
      @(negedge clk_i); cap_pin_i[0] = 1'b1;
      idle(4);
      rd(3'd4, v);
      chk($sformatf("R3 rise cfg=%0d", cfg), v & 1, cfg & 1);
      wr(3'd4, 16'h0007);
      @(negedge clk_i); cap_pin_i[0] = 1'b0;
      idle(4);
      rd(3'd4, v);
      chk($sformatf("R3 fall cfg=%0d", cfg), v & 1, (cfg >> 1) & 1);
    end

    // R4: restart on capture, count right after the event
    wr(3'd2, 16'h0005);
    wr(3'd5, 16'h0800);
    @(negedge clk_i); cap_pin_i[0] = 1'b1;
    idle(3);
    rd(3'd5, v);
    chk("R4 count cleared", v, 0);
    rd(3'd6, v);
    chk("R4 cap keeps pre-clear count", int'(v >= 16'h0800), 1);
    idle(2);
    rd(3'd5, v);
    chk("R4 count restarted", v, 2);
    @(negedge clk_i); cap_pin_i[0] = 1'b0;
    idle(4);

    // R2: period and high-time sweep; ch0 rise+restart, ch1 fall
    wr(3'd2, 16'h0025);
    for (int p = 0; p < 4; p++) begin
      wr(3'd1, 16'(p));
      for (int k = 0; k < 4; k++) begin
        int h, t;
        h = (k == 0) ? 3 : (k == 1) ? 5 : (k == 2) ? 1 : 6;
        t = (k == 0) ? 10 : (k == 1) ? 7 : (k == 2) ? 4 : 13;
        @(negedge clk_i); cap_pin_i = 2'b11;
        idle(h);
        cap_pin_i = 2'b00;
        idle(t - h);
        cap_pin_i = 2'b11;
        idle(4);
        rd(3'd6, v);
        chk($sformatf("R2 period p=%0d t=%0d", p, t), v, (t - 1) / (p + 1));
        rd(3'd7, v);
        chk($sformatf("R2 high p=%0d h=%0d", p, h), v, (h - 1) / (p + 1));
        cap_pin_i = 2'b00;
        idle(4);
      end
    end

    // R9: simultaneous capture, restart from channel 1 only
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0051);
    wr(3'd5, 16'h0300);
    idle(2);
    @(negedge clk_i); cap_pin_i = 2'b11;
    idle(4);
    rd(3'd6, v);
    rd(3'd7, v2);
    chk("R9 same count", v, v2);
    chk("R9 pre-restart value", int'(v >= 16'h0300), 1);
    rd(3'd5, v);
    chk("R9 single restart", v, 1);
    cap_pin_i = 2'b00;
    idle(4);

    // R5: run clear
    wr(3'd2, 16'h0003);
    wr(3'd0, 16'h0000);
    wr(3'd6, 16'h1234);
    wr(3'd4, 16'h0007);
    rd(3'd5, c);
    idle(10);
    rd(3'd5, v);
    chk("R5 count holds", v, c);
    @(negedge clk_i); cap_pin_i[0] = 1'b1;
    idle(4);
    rd(3'd6, v);
    chk("R5 no capture", v, 16'h1234);
    rd(3'd4, v);
    chk("R5 no pending", v & 1, 0);
    cap_pin_i[0] = 1'b0;
    idle(4);

    // R8: wrap sets pending, irq gating, write-1 clear
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'h0007);
    wr(3'd5, 16'hFFFF);
    idle(2);
    rd(3'd4, v);
    chk("R8 wrap pending", v, 4);
    chk("R8 irq masked", int'(irq_o), 0);
    wr(3'd3, 16'h0004);
    chk("R8 irq enabled", int'(irq_o), 1);
    wr(3'd3, 16'h0003);
    chk("R8 irq other enables", int'(irq_o), 0);

    // R6/R7: sleep
    wr(3'd0, 16'h0003);
    rd(3'd5, c);
    rd(3'd6, v2);
    idle(10);
    rd(3'd5, v);
    chk("R6 count frozen", v, c);
    wr(3'd5, 16'h5555);
    rd(3'd5, v);
    chk("R6 count write ignored", v, c);
    wr(3'd6, 16'h7777);
    rd(3'd6, v);
    chk("R6 cap write ignored", v, v2);
    wr(3'd1, 16'h0042);
    rd(3'd1, v);
    chk("R6 prescale write", v, 16'h0042);
    wr(3'd3, 16'h0005);
    rd(3'd3, v);
    chk("R6 enable write", v, 5);
    @(negedge clk_i); cap_pin_i[0] = 1'b1;
    idle(4);
    rd(3'd6, v);
    chk("R6 no capture in sleep", v, v2);
    wr(3'd4, 16'h0007);
    rd(3'd4, v);
    chk("R7 pending kept", v, 4);
    chk("R7 irq kept", int'(irq_o), 1);

    // R8: clear after wake
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'h0004);
    rd(3'd4, v);
    chk("R8 w1c clear", v & 4, 0);
    chk("R8 irq low", int'(irq_o), 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule